// File: doc/BRIEF.md
# ATA PIO Register Access Engine

This block carries out one task-file register access at a time on a parallel ATA/IDE device port, using programmed I/O. A requester hands over a read or write, a 5-bit register address and, for writes, a 16-bit value. The engine then steps the pins through a fixed sequence of phases. It turns the shared 16-bit data bus around, presents the address, drives the data and pulses the right strobe. It then removes the address and releases the bus. It reports completion with a one-cycle done pulse and, for reads, leaves the captured word on a result port.

Each phase lasts a parameterized number of system clocks, so the same logic meets slow and fast device timing. A separate request produces a device reset pulse of parameterized length. The device interrupt line is synchronized, and it is forwarded only while no access or reset is under way.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset and whenever idle, `ata_addr_o` equals the deselected value 5'b11000, `ata_rd_no`, `ata_wr_no` and `ata_rst_no` are high, the data bus is not driven by the engine, and `busy_o` is low.
- R2: A request (`req_valid_i` high) is accepted only while idle. `busy_o` is high from the cycle after acceptance through the done cycle. A request raised while busy has no effect and is not queued. Request addresses always have at least one of bits [4:3] low, because those bits are active-low chip selects.
- R3: A write drives the bus from the first cycle after acceptance. The address is presented for SETUP_CYC cycles, then the write value is driven for one cycle, and then `ata_wr_no` is low for PULSE_CYC cycles while the bus carries the write value.
- R4: After the write strobe rises, address and data stay for HOLD_CYC cycles. The address then returns to 5'b11000 for one cycle with data still driven. The bus is then released for RECOV_CYC cycles, so a device latching on the strobe's rising edge stores the write value.
- R5: A read follows the same phase timing with `ata_rd_no` as the strobe. The engine never drives the bus and `ata_wr_no` stays high. `rdata_o` takes the bus value sampled on the last clock edge of the strobe-low window.
- R6: An access occupies exactly 3+SETUP_CYC+PULSE_CYC+HOLD_CYC+RECOV_CYC busy cycles. `done_o` is high only in the last of them, and the engine is idle in the next cycle.
- R7: `irq_o` follows `irq_i` two clocks later while idle. It is held low in every cycle in which `busy_o` is high, and it returns in the first idle cycle after done.
- R8: A reset request accepted in idle holds `ata_rst_no` low for exactly RESET_CYC cycles, with `busy_o` high and both strobes high. Access requests during it are ignored. When a reset request and an access request arrive in the same idle cycle, the reset wins and the access is dropped.
- R9: `rdata_o` keeps the last read result through later writes and idle time until another read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request, sampled when idle |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_addr_i | input | 5 | {cs1_n, cs0_n, reg[2:0]} of the target register |
| req_wdata_i | input | 16 | Write value |
| rst_req_i | input | 1 | Request a device reset pulse |
| busy_o | output | 1 | Access or reset in progress |
| done_o | output | 1 | One-cycle completion pulse of an access |
| rdata_o | output | 16 | Last read result |
| irq_o | output | 1 | Synchronized, masked device interrupt |
| ata_data_io | inout | 16 | Bidirectional device data bus |
| ata_addr_o | output | 5 | Chip selects and register address to device |
| ata_rd_no | output | 1 | Read strobe, active low |
| ata_wr_no | output | 1 | Write strobe, active low |
| ata_rst_no | output | 1 | Device reset, active low |
| irq_i | input | 1 | Device interrupt request |

## Verification
Two events can meet in a single idle cycle. A reset request and an access request may be raised on the same clock, and an interrupt may be pending just as an access starts. The bench raises both requests together and expects a reset pulse of exact length with no strobe, and it expects the target register in its device model to be left unchanged. It also holds the interrupt high across whole accesses and expects `irq_o` low in every busy cycle, then high in the first idle cycle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_TURN, PH_ADDR, PH_DATA, PH_STRB,
    PH_HOLD, PH_DESEL, PH_REL, PH_RST
  } phase_e;
endpackage

// File: rtl/ata_phase_seq.sv
module ata_phase_seq
  import ata_pio_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int CW        = 5,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 1,
  parameter int RECOV_CYC = 2,
  parameter int RESET_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          rst_req_i,
  output phase_e        phase_o,
  output logic          last_o,
  output logic          cur_write_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [DW-1:0] cur_wdata_o,
  output logic          busy_o,
  output logic          done_o
);
  phase_e        phase_q, phase_n;
  logic [CW-1:0] cnt_q, len_n;

  always_comb begin
    phase_n = PH_IDLE;
    len_n   = '0;
    unique case (phase_q)
      PH_TURN:  begin phase_n = PH_ADDR;  len_n = CW'(SETUP_CYC - 1); end
      PH_ADDR:  begin phase_n = PH_DATA;  len_n = '0;                 end
      PH_DATA:  begin phase_n = PH_STRB;  len_n = CW'(PULSE_CYC - 1); end
      PH_STRB:  begin phase_n = PH_HOLD;  len_n = CW'(HOLD_CYC - 1);  end
      PH_HOLD:  begin phase_n = PH_DESEL; len_n = '0;                 end
      PH_DESEL: begin phase_n = PH_REL;   len_n = CW'(RECOV_CYC - 1); end
      default:  begin phase_n = PH_IDLE;  len_n = '0;                 end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      cur_write_o <= 1'b0;
      cur_addr_o  <= '0;
      cur_wdata_o <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (rst_req_i) begin
        // reset wins over a same-cycle access
        phase_q <= PH_RST;
        cnt_q   <= CW'(RESET_CYC - 1);
      end else if (req_valid_i) begin
        phase_q     <= PH_TURN;
        cnt_q       <= '0;
        cur_write_o <= req_write_i;
        cur_addr_o  <= req_addr_i;
        cur_wdata_o <= req_wdata_i;
      end
    end else if (cnt_q == '0) begin
      phase_q <= phase_n;
      cnt_q   <= len_n;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign last_o  = (cnt_q == '0);
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = (phase_q == PH_REL) && (cnt_q == '0);

  // R2
  accept_only_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i || rst_req_i));
  // R6
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/ata_pin_drive.sv
module ata_pin_drive
  import ata_pio_pkg::*;
#(
  parameter int            AW        = 5,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] DESEL_ADR = 5'b11000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          last_i,
  input  logic          cur_write_i,
  input  logic [AW-1:0] cur_addr_i,
  input  logic [DW-1:0] cur_wdata_i,
  input  logic [DW-1:0] bus_in_i,
  output logic [DW-1:0] bus_out_o,
  output logic          bus_oe_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic          rst_no,
  output logic [DW-1:0] rdata_o
);
  logic addr_on, data_on, strobe;

  assign addr_on = phase_i inside {PH_ADDR, PH_DATA, PH_STRB, PH_HOLD};
  assign data_on = phase_i inside {PH_DATA, PH_STRB, PH_HOLD, PH_DESEL};
  assign strobe  = (phase_i == PH_STRB);

  assign bus_oe_o  = cur_write_i && (phase_i inside {PH_TURN, PH_ADDR, PH_DATA,
                                                     PH_STRB, PH_HOLD, PH_DESEL});
  assign bus_out_o = data_on ? cur_wdata_i : '0;
  assign addr_o    = addr_on ? cur_addr_i : DESEL_ADR;
  assign wr_no     = !(strobe && cur_write_i);
  assign rd_no     = !(strobe && !cur_write_i);
  assign rst_no    = (phase_i != PH_RST);

  // capture on the edge that ends the read strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              rdata_o <= '0;
    else if (strobe && last_i && !cur_write_i) rdata_o <= bus_in_i;
  end

  // R3
  strobes_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  // R4
  addr_held_at_wr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (addr_o != DESEL_ADR) && bus_oe_o);
  // R5
  read_never_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !bus_oe_o);
  // R8
  quiet_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> rd_no && wr_no && !bus_oe_o);
endmodule

// File: rtl/ata_irq_gate.sv
module ata_irq_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic mask_i,
  output logic irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], irq_i};
  end

  assign irq_o = sync_q[SYNC_STAGES-1] && !mask_i;

  // R7
  irq_from_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_i, 2));
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 1,
  parameter int RECOV_CYC = 2,
  parameter int RESET_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          rst_req_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  inout  wire  [DW-1:0] ata_data_io,
  output logic [AW-1:0] ata_addr_o,
  output logic          ata_rd_no,
  output logic          ata_wr_no,
  output logic          ata_rst_no,
  input  logic          irq_i
);
  localparam int M1 = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2 = (HOLD_CYC > RECOV_CYC) ? HOLD_CYC : RECOV_CYC;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MX = (M3 > RESET_CYC) ? M3 : RESET_CYC;
  localparam int CW = $clog2(MX) + 1;

  phase_e        phase;
  logic          last, cur_write, bus_oe;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata, bus_out;

  ata_phase_seq #(
    .AW(AW), .DW(DW), .CW(CW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .RECOV_CYC(RECOV_CYC), .RESET_CYC(RESET_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .rst_req_i,
    .phase_o(phase), .last_o(last), .cur_write_o(cur_write),
    .cur_addr_o(cur_addr), .cur_wdata_o(cur_wdata),
    .busy_o, .done_o
  );

  ata_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .clk_i, .rst_ni,
    .phase_i(phase), .last_i(last), .cur_write_i(cur_write),
    .cur_addr_i(cur_addr), .cur_wdata_i(cur_wdata),
    .bus_in_i(ata_data_io), .bus_out_o(bus_out), .bus_oe_o(bus_oe),
    .addr_o(ata_addr_o), .rd_no(ata_rd_no), .wr_no(ata_wr_no),
    .rst_no(ata_rst_no), .rdata_o
  );

  ata_irq_gate #(.SYNC_STAGES(2)) u_irq (
    .clk_i, .rst_ni, .irq_i, .mask_i(busy_o), .irq_o
  );

  assign ata_data_io = bus_oe ? bus_out : 'z;
endmodule

// File: tb/ata_pio_engine_bench.sv
module ata_pio_engine_bench;
  localparam int S = 2, P = 4, H = 1, RC = 2, RST = 16;
  localparam int TOTAL = 3 + S + P + H + RC;
  localparam logic [4:0] DESEL = 5'b11000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, req_valid = 1'b0, req_write = 1'b0, rst_req = 1'b0, irq = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, irq_out, rd_n, wr_n, dev_rst_n;
  logic [15:0] rdata;
  logic [4:0]  ata_addr;
  wire  [15:0] ata_bus;
  logic [15:0] dev_mem [32];

  ata_pio_engine #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .RECOV_CYC(RC),
                   .RESET_CYC(RST)) u_ata_pio_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rst_req_i(rst_req),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .irq_o(irq_out),
    .ata_data_io(ata_bus), .ata_addr_o(ata_addr), .ata_rd_no(rd_n),
    .ata_wr_no(wr_n), .ata_rst_no(dev_rst_n), .irq_i(irq)
  );

  // device model: drives on read strobe, latches on write strobe rise
  assign ata_bus = !rd_n ? dev_mem[ata_addr] : 'z;
  always @(posedge wr_n) if (rst_n) dev_mem[ata_addr] <= ata_bus;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_addr(int k, logic [4:0] a);
    return (k >= 2 && k <= S + 2 + P + H) ? a : DESEL;
  endfunction

  function automatic bit strobe_cyc(int k);
    return (k >= S + 3 && k <= S + 2 + P);
  endfunction

  function automatic logic [4:0] rand_addr();
    logic [1:0] cs;
    cs = 2'($urandom % 3);
    return {cs, 3'($urandom)};
  endfunction

  task automatic access(input bit wr, input logic [4:0] a, input logic [15:0] d,
                        input bit poke);
    int k, addr_bad, wr_bad, rd_bad, bus_bad, busy_bad, irq_bad, done_k;
    logic [4:0]  pa;
    logic [15:0] pold, rd_exp;
    pa = {a[4:3], a[2:0] ^ 3'd1};
    pold = dev_mem[pa];
    rd_exp = dev_mem[a];
    addr_bad = 0; wr_bad = 0; rd_bad = 0; bus_bad = 0; busy_bad = 0; irq_bad = 0;
    done_k = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (k = 1; k <= 60; k++) begin
      if (ata_addr !== exp_addr(k, a)) addr_bad++;
      if (wr_n !== !(wr && strobe_cyc(k))) wr_bad++;
      if (rd_n !== !(!wr && strobe_cyc(k))) rd_bad++;
      if (wr && strobe_cyc(k) && ata_bus !== d) bus_bad++;
      if (busy !== 1'b1) busy_bad++;
      if (irq_out !== 1'b0) irq_bad++;
      if (poke && k == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = pa; req_wdata = ~d;
      end
      if (poke && k == 4) req_valid = 1'b0;
      if (done === 1'b1) begin done_k = k; break; end
      @(negedge clk);
    end
    chk(addr_bad == 0, "R3", "address phase mismatches", addr_bad, 0);
    chk(wr_bad == 0, "R3", "write strobe mismatches", wr_bad, 0);
    chk(rd_bad == 0, "R5", "read strobe mismatches", rd_bad, 0);
    if (wr) chk(bus_bad == 0, "R3", "bus value during strobe", bus_bad, 0);
    chk(busy_bad == 0, "R2", "busy low during access", busy_bad, 0);
    chk(irq_bad == 0, "R7", "irq leaked while busy", irq_bad, 0);
    chk(done_k == TOTAL, "R6", "access length", done_k, TOTAL);
    @(negedge clk);
    chk(!done && !busy, "R6", "done single cycle then idle", {done, busy}, 0);
    chk(irq_out === irq, "R7", "irq returns after release", irq_out, irq);
    if (wr) chk(dev_mem[a] == d, "R4", "device stored write", dev_mem[a], d);
    else    chk(rdata == rd_exp, "R5", "read result", rdata, rd_exp);
    if (poke) chk(dev_mem[pa] == pold, "R2", "request while busy ignored",
                  dev_mem[pa], pold);
  endtask

  task automatic reset_with_access();
    int n, strb_bad;
    logic [15:0] old;
    old = dev_mem[5'b00001];
    n = 0; strb_bad = 0;
    @(negedge clk);
    rst_req = 1'b1; req_valid = 1'b1; req_write = 1'b1;
    req_addr = 5'b00001; req_wdata = ~old;
    @(negedge clk);
    rst_req = 1'b0; req_valid = 1'b0;
    while (!dev_rst_n && n < 1000) begin
      n++;
      if (!wr_n || !rd_n || !busy) strb_bad++;
      if (n == 2) req_valid = 1'b1;
      if (n == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(n == RST, "R8", "reset pulse length", n, RST);
    chk(strb_bad == 0, "R8", "strobe or idle during reset", strb_bad, 0);
    chk(!busy, "R8", "idle after reset", busy, 0);
    chk(dev_mem[5'b00001] == old, "R8", "same-cycle access dropped",
        dev_mem[5'b00001], old);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] keep;
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) dev_mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle state
    chk(ata_addr == DESEL, "R1", "idle address", ata_addr, DESEL);
    chk(rd_n && wr_n && dev_rst_n, "R1", "idle strobes/reset", {rd_n, wr_n, dev_rst_n}, 3'b111);
    chk(!busy && !done, "R1", "idle busy/done", {busy, done}, 0);

    access(1'b1, 5'b10010, 16'hA5C3, 1'b0);
    access(1'b0, 5'b10010, 16'h0000, 1'b0);
    access(1'b1, 5'b01111, 16'h0000, 1'b0);
    access(1'b1, 5'b00000, 16'hFFFF, 1'b1);
    access(1'b0, 5'b01101, 16'h0000, 1'b1);

    reset_with_access();

    // R7 irq passes when idle, two-clock latency
    @(negedge clk); irq = 1'b1;
    @(negedge clk);
    chk(irq_out == 1'b0, "R7", "irq after one clock", irq_out, 0);
    @(negedge clk);
    chk(irq_out == 1'b1, "R7", "irq after two clocks", irq_out, 1);
    access(1'b1, 5'b10110, 16'h1234, 1'b0);
    access(1'b0, 5'b10110, 16'h0000, 1'b0);
    @(negedge clk); irq = 1'b0;

    for (int i = 0; i < 60; i++)
      access(1'($urandom), rand_addr(), 16'($urandom), (i % 7) == 3);

    // R9 read result survives writes and idle
    access(1'b0, 5'b00011, 16'h0000, 1'b0);
    keep = rdata;
    access(1'b1, 5'b00100, 16'hBEEF, 1'b0);
    repeat (5) @(negedge clk);
    chk(rdata == keep, "R9", "read result held", rdata, keep);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule